// File: doc/BRIEF.md
# Parallel Bus Command/Data Write Engine

The engine sits on the host side of a display controller that has an 8-bit, strobe-per-write parallel bus. Logic inside the chip gives it one byte at a time on a valid/ready port. Each byte carries a flag that marks it as a command or as parameter/pixel data. The engine turns each byte into one timed write cycle on the bus pins. It drives chip select, the register-select line, the write strobe and a read strobe that stays inactive. The byte sits on the upper eight lines of a nine-line data bus, and the lowest line is held at 0.

Every timing minimum of the bus is a parameter counted in system clocks, rounded up from the nanosecond figure. The minimums are address setup and hold, strobe low and high widths, data setup and hold, and the full cycle time. With the defaults and a 5 ns clock, one write lasts 20 clocks: 1 setup clock, then 9 strobe-low clocks, then 10 strobe-high clocks. Chip select stays low across bytes offered back to back. It rises once the port has no further byte.

The state machine has four states. IDLE: the bus is quiet and a byte may be taken. ADDR_SETUP: chip select, register select and data are on the bus and the strobe is still high. STROBE_LOW: the write strobe is low. STROBE_HIGH: the strobe is high again and data is held. The transitions are:
- IDLE to ADDR_SETUP when a byte is accepted.
- ADDR_SETUP to STROBE_LOW when the setup count expires.
- STROBE_LOW to STROBE_HIGH when the low count expires.
- STROBE_HIGH to ADDR_SETUP when the high count expires and a new byte is accepted in that same cycle.
- STROBE_HIGH to IDLE when the high count expires and no byte is offered.

Top module: `pbus_wr_engine`

## Requirements
- R1: During and after reset, chip select is 1, the write strobe is 1, the read strobe is 1, the data bus is 0, in_ready is 1 and idle is 1.
- R2: A byte offered with in_is_data=0 is written with register select 0 (command). A byte offered with in_is_data=1 is written with register select 1 (data).
- R3: The byte appears on bus_d[8:1] and bus_d[0] is 0. Data and register select do not change while the strobe is low. They also hold for at least DH_CLK (default 2) clocks after the strobe rises.
- R4: The read strobe stays 1 at all times.
- R5: The write strobe is low only while chip select is low. At the start of a burst, chip select falls exactly AS_CLK (default 1) clocks before the strobe falls.
- R6: The write strobe stays low for exactly max(WL_CLK, DS_CLK-AS_CLK) clocks (default 9).
- R7: Between two writes of one burst, the strobe falls every AS_CLK + low length + high length clocks (default 20). The high length is max(WH_CLK, DH_CLK, AH_CLK, CYC_CLK-AS_CLK-low length), which is 10 by default.
- R8: in_ready is 0 from acceptance until the last clock of the strobe-high phase, and 1 in that clock and in IDLE. A byte is taken only when in_valid and in_ready are both 1.
- R9: A byte accepted in the last high clock keeps chip select low. When no byte is offered, chip select rises exactly the high length (default 10) clocks after the strobe rises.
- R10: idle is 1 only in IDLE. In IDLE chip select and the strobe are both 1. A reset in the middle of a write returns the bus to the R1 values at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A byte is offered |
| in_ready | output | 1 | The engine can take a byte this clock |
| in_byte | input | 8 | Byte to write |
| in_is_data | input | 1 | 1 = parameter/pixel data, 0 = command |
| idle | output | 1 | Engine is in IDLE |
| bus_csb | output | 1 | Chip select, active low |
| bus_rs | output | 1 | Register select: 0 command, 1 data |
| bus_wrb | output | 1 | Write strobe, active low |
| bus_rdb | output | 1 | Read strobe, held high |
| bus_d | output | 9 | Data lines; byte on [8:1], [0] = 0 |

## Verification
The bench measures every strobe from the pins: its low width, the fall-to-fall period inside a burst, and the setup clocks at the start of each burst. A design that miscounts any phase by one clock shows up as a width or a period of 8, 10, 19 or 21. Register select changes between back-to-back bytes, so a design that updates it early corrupts a write, and a design that updates it late tags the next byte wrongly. Gaps between bursts check that chip select rises after exactly the high phase: a design that drops a burst's chip select between bytes, or never raises it, miscounts the bursts. A reset applied while the strobe is low must release the bus at once.

// File: rtl/pbus_wr_pkg.sv
package pbus_wr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR_SETUP,
        ST_STROBE_LOW,
        ST_STROBE_HIGH
    } wr_state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pbus_phase_timer.sv
module pbus_phase_timer #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/pbus_pin_drive.sv
module pbus_pin_drive #(
    parameter int DW = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        csb_nx,
    input  logic        rs_nx,
    input  logic        wrb_nx,
    input  logic [DW:0] d_nx,
    output logic        csb,
    output logic        rs,
    output logic        wrb,
    output logic        rdb,
    output logic [DW:0] d
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csb <= 1'b1;
            rs  <= 1'b0;
            wrb <= 1'b1;
            d   <= '0;
        end else begin
            csb <= csb_nx;
            rs  <= rs_nx;
            wrb <= wrb_nx;
            d   <= d_nx;
        end
    end

    assign rdb = 1'b1;

    // R5
    strobe_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wrb |-> !csb);

endmodule

// File: rtl/pbus_wr_engine.sv
module pbus_wr_engine #(
    parameter int BYTE_W  = 8,
    parameter int AS_CLK  = 1,
    parameter int AH_CLK  = 1,
    parameter int WL_CLK  = 9,
    parameter int WH_CLK  = 9,
    parameter int DS_CLK  = 6,
    parameter int DH_CLK  = 2,
    parameter int CYC_CLK = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_is_data,
    output logic              idle,
    output logic              bus_csb,
    output logic              bus_rs,
    output logic              bus_wrb,
    output logic              bus_rdb,
    output logic [BYTE_W:0]   bus_d
);
    import pbus_wr_pkg::*;

    localparam int SETUP_LEN = pbus_wr_pkg::max2(AS_CLK, 1);
    localparam int LO_LEN    = pbus_wr_pkg::max2(pbus_wr_pkg::max2(WL_CLK, DS_CLK - SETUP_LEN), 1);
    localparam int HI_LEN    = pbus_wr_pkg::max2(
                                   pbus_wr_pkg::max2(WH_CLK, DH_CLK),
                                   pbus_wr_pkg::max2(pbus_wr_pkg::max2(AH_CLK, 1),
                                                     CYC_CLK - SETUP_LEN - LO_LEN));
    localparam int MAX_LEN   = pbus_wr_pkg::max2(SETUP_LEN, pbus_wr_pkg::max2(LO_LEN, HI_LEN));
    localparam int CW        = $clog2(MAX_LEN + 1) + 1;

    wr_state_e     state, state_nx;
    logic          accept;
    logic          phase_done;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;

    logic              csb_nx, rs_nx, wrb_nx;
    logic [BYTE_W:0]   d_nx;

    assign in_ready = (state == ST_IDLE) || ((state == ST_STROBE_HIGH) && phase_done);
    assign accept   = in_valid && in_ready;
    assign idle     = (state == ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:        if (accept)     state_nx = ST_ADDR_SETUP;
            ST_ADDR_SETUP:  if (phase_done) state_nx = ST_STROBE_LOW;
            ST_STROBE_LOW:  if (phase_done) state_nx = ST_STROBE_HIGH;
            ST_STROBE_HIGH: if (phase_done) state_nx = accept ? ST_ADDR_SETUP : ST_IDLE;
        endcase
    end

    // phase length for the state being entered
    always_comb begin
        tmr_load = (state_nx != state);
        unique case (state_nx)
            ST_ADDR_SETUP:  tmr_val = CW'(SETUP_LEN - 1);
            ST_STROBE_LOW:  tmr_val = CW'(LO_LEN - 1);
            ST_STROBE_HIGH: tmr_val = CW'(HI_LEN - 1);
            default:        tmr_val = '0;
        endcase
    end

    pbus_phase_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (phase_done)
    );

    // outputs: next pin values
    always_comb begin
        csb_nx = bus_csb;
        rs_nx  = bus_rs;
        wrb_nx = bus_wrb;
        d_nx   = bus_d;
        if (accept) begin
            csb_nx = 1'b0;
            rs_nx  = in_is_data;
            wrb_nx = 1'b1;
            d_nx   = {in_byte, 1'b0};
        end else begin
            unique case (state)
                ST_IDLE:        csb_nx = 1'b1;
                ST_ADDR_SETUP:  if (phase_done) wrb_nx = 1'b0;
                ST_STROBE_LOW:  if (phase_done) wrb_nx = 1'b1;
                ST_STROBE_HIGH: if (phase_done) csb_nx = 1'b1;
            endcase
        end
    end

    pbus_pin_drive #(.DW(BYTE_W)) u_pins (
        .clk    (clk),
        .rst_n  (rst_n),
        .csb_nx (csb_nx),
        .rs_nx  (rs_nx),
        .wrb_nx (wrb_nx),
        .d_nx   (d_nx),
        .csb    (bus_csb),
        .rs     (bus_rs),
        .wrb    (bus_wrb),
        .rdb    (bus_rdb),
        .d      (bus_d)
    );

    // checker: consecutive low clocks of the strobe
    logic [CW:0] lo_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_run <= '0;
        end else if (!bus_wrb) begin
            lo_run <= lo_run + 1'b1;
        end else begin
            lo_run <= '0;
        end
    end

    // R6
    strobe_low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_wrb) |-> (lo_run == (CW+1)'(LO_LEN)));

    // R3
    data_stable_in_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wrb |=> ($stable(bus_d) && $stable(bus_rs)));

    // R8
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wrb |-> !in_ready);

    // R5
    select_held_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wrb |=> !bus_csb);

    // R10
    idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (bus_csb && bus_wrb));

    // R9
    select_rise_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_csb) |-> idle);

endmodule

// File: tb/pbus_wr_engine_tb.sv
module pbus_wr_engine_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_byte = 8'h00;
    logic       in_is_data = 1'b0;
    logic       idle;
    logic       bus_csb, bus_rs, bus_wrb, bus_rdb;
    logic [8:0] bus_d;

    always #2.5 clk = ~clk;

    pbus_wr_engine u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_byte    (in_byte),
        .in_is_data (in_is_data),
        .idle       (idle),
        .bus_csb    (bus_csb),
        .bus_rs     (bus_rs),
        .bus_wrb    (bus_wrb),
        .bus_rdb    (bus_rdb),
        .bus_d      (bus_d)
    );

    // expected timing, from the requirements with default parameters
    localparam int EXP_SETUP  = 1;
    localparam int EXP_LOW    = 9;
    localparam int EXP_HIGH   = 10;
    localparam int EXP_PERIOD = 20;
    localparam int EXP_HOLD   = 2;

    // {gap[17:9], is_data[8], byte[7:0]}
    localparam int NV = 10;
    localparam logic [17:0] VEC [NV] = '{
        {9'd0,  1'b0, 8'h06},
        {9'd0,  1'b1, 8'h00},
        {9'd0,  1'b1, 8'hA5},
        {9'd40, 1'b0, 8'h17},
        {9'd0,  1'b1, 8'hFF},
        {9'd0,  1'b0, 8'h18},
        {9'd0,  1'b1, 8'h9F},
        {9'd40, 1'b0, 8'h22},
        {9'd0,  1'b1, 8'h01},
        {9'd40, 1'b1, 8'h80}
    };

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // pin monitor
    bit   mon_en = 1'b0;
    bit   prev_wrb = 1'b1, prev_csb = 1'b1, burst_first = 1'b0;
    int   n_wr = 0, n_burst = 0;
    int   since_fall = 0, low_run = 0, hi_run = 0, setup_run = 0;
    int   cap_d [16], cap_rs [16], cap_lo [16], cap_per [16], cap_setup [16];
    int   cap_csb_hi [8];
    int   ready_viol = 0, rdb_viol = 0, d0_viol = 0, hold_viol = 0;

    always @(negedge clk) begin
        if (mon_en) begin
            if (!bus_wrb && in_ready) ready_viol++;
            if (!bus_rdb) rdb_viol++;
            if (bus_d[0]) d0_viol++;
            if (prev_csb && !bus_csb) begin
                setup_run   = 0;
                burst_first = 1'b1;
            end
            if (!bus_csb && bus_wrb && burst_first) setup_run++;
            if (prev_wrb && !bus_wrb) begin
                cap_per[n_wr]   = burst_first ? 0 : since_fall;
                cap_setup[n_wr] = setup_run;
                burst_first     = 1'b0;
                since_fall      = 1;
                low_run         = 1;
            end else begin
                since_fall++;
                if (!bus_wrb) low_run++;
            end
            if (!prev_wrb && bus_wrb && n_wr < 16) begin
                cap_lo[n_wr] = low_run;
                cap_d[n_wr]  = int'(bus_d);
                cap_rs[n_wr] = int'(bus_rs);
                n_wr++;
                hi_run = 1;
            end else if (bus_wrb && !bus_csb) begin
                hi_run++;
                if (hi_run <= EXP_HOLD && n_wr > 0 && int'(bus_d) != cap_d[n_wr-1]) hold_viol++;
            end
            if (!prev_csb && bus_csb && n_burst < 8) begin
                cap_csb_hi[n_burst] = hi_run;
                n_burst++;
            end
            prev_wrb = bus_wrb;
            prev_csb = bus_csb;
        end
    end

    task automatic send(input bit is_data, input logic [7:0] b);
        in_valid   = 1'b1;
        in_is_data = is_data;
        in_byte    = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int bi;
        // R1 reset state
        repeat (3) @(negedge clk);
        check(bus_csb == 1'b1, "R1 csb", bus_csb, 1);
        check(bus_wrb == 1'b1, "R1 wrb", bus_wrb, 1);
        check(bus_rdb == 1'b1, "R1 rdb", bus_rdb, 1);
        check(bus_d == 9'd0,   "R1 data", bus_d, 0);
        check(in_ready == 1'b1, "R1 ready", in_ready, 1);
        check(idle == 1'b1,    "R1 idle", idle, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(bus_csb == 1'b1 && in_ready && idle, "R1 after release", {bus_csb, in_ready, idle}, 7);
        mon_en = 1'b1;

        // table walk
        for (int i = 0; i < NV; i++) begin
            repeat (int'(VEC[i][17:9])) @(negedge clk);
            send(VEC[i][8], VEC[i][7:0]);
        end
        repeat (40) @(negedge clk);

        check(n_wr == NV, "R8 write count", n_wr, NV);
        bi = 0;
        for (int i = 0; i < NV; i++) begin
            bit start;
            start = (i == 0) || (VEC[i][17:9] != 0);
            check(cap_d[i] == int'({VEC[i][7:0], 1'b0}), "R3 byte on d[8:1]", cap_d[i], int'({VEC[i][7:0], 1'b0}));
            check(cap_rs[i] == int'(VEC[i][8]), "R2 register select", cap_rs[i], int'(VEC[i][8]));
            check(cap_lo[i] == EXP_LOW, "R6 strobe low width", cap_lo[i], EXP_LOW);
            if (start) begin
                check(cap_setup[i] == EXP_SETUP, "R5 select setup", cap_setup[i], EXP_SETUP);
                bi++;
            end else begin
                check(cap_per[i] == EXP_PERIOD, "R7 back-to-back period", cap_per[i], EXP_PERIOD);
            end
        end
        check(n_burst == bi, "R9 bursts (select rises)", n_burst, bi);
        for (int k = 0; k < 4; k++)
            check(cap_csb_hi[k] == EXP_HIGH, "R9 select rise delay", cap_csb_hi[k], EXP_HIGH);
        check(ready_viol == 0, "R8 ready low while strobe low", ready_viol, 0);
        check(rdb_viol == 0, "R4 read strobe high", rdb_viol, 0);
        check(d0_viol == 0, "R3 d[0] zero", d0_viol, 0);
        check(hold_viol == 0, "R3 data hold", hold_viol, 0);
        check(idle == 1'b1 && bus_csb, "R10 idle after run", {idle, bus_csb}, 3);

        // ready is only high at its window: start a write and look mid-cycle
        mon_en = 1'b0;
        send(1'b1, 8'h3C);
        repeat (4) @(negedge clk);
        check(bus_wrb == 1'b0, "R6 strobe low mid-write", bus_wrb, 0);
        check(in_ready == 1'b0, "R8 busy not ready", in_ready, 0);
        check(idle == 1'b0, "R10 not idle in write", idle, 0);
        // offer a byte that must not be taken while busy
        in_valid = 1'b1; in_is_data = 1'b0; in_byte = 8'h55;
        @(negedge clk);
        check(bus_d == {8'h3C, 1'b0}, "R8 busy offer ignored", bus_d, {8'h3C, 1'b0});
        in_valid = 1'b0;
        // mid-write reset
        #1 rst_n = 1'b0;
        #1;
        check(bus_csb == 1'b1 && bus_wrb == 1'b1, "R10 reset releases bus", {bus_csb, bus_wrb}, 3);
        check(bus_d == 9'd0 && in_ready && idle, "R1 reset mid-write", bus_d, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(bus_csb && bus_wrb && idle, "R10 quiet after reset", {bus_csb, bus_wrb, idle}, 7);
        finish_run();
    end

endmodule